// File: doc/BRIEF.md
# Fuse Macro Read Sequencer

This block sits between a simple 32-bit register bus and the pin interface of a one-time-programmable fuse macro. Software can drive the macro's chip-select, strobe, load and address pins directly through a control register. It then picks up the sensed byte from a data-out register. The program-enable pin is held in its inactive (high) state by hardware, so nothing issued through this block can burn a fuse.

For multi-byte reads, a hardware sequencer takes over the pins. Software writes a settle interval (in clock cycles), then a start address and byte count with a launch bit. The sequencer opens a read session and runs the address/strobe handshake for each consecutive byte. Each sampled byte is presented on a side port with a one-cycle valid pulse. At the end the pins are parked in the standby state and a one-cycle done pulse is raised.

Top module: `efuse_rd_ctrl`

## Requirements
- R1: After reset the pins are in standby (chip select high, program enable high, load, strobe and address zero), so offset 0x0 reads 0x0000_0009. Data-out reads zero, busy is low and the settle register reads 100.
- R2: A write to offset 0x0 while idle drives the pins: bit 0 chip select (active low), bit 1 strobe, bit 2 load, bits [15:6] the 10-bit fuse address. A read of 0x0 returns the current pin state with all unused bits zero.
- R3: Offset 0x4 bits [7:0] hold the last sampled byte and bits [31:8] read zero. While idle, the macro output is captured on every clock in which the strobe pin is high. During a burst, the byte is captured once at each sample step.
- R4: A write to offset 0x8 with bit 31 set, start address in bits [9:0] and byte count in bits [23:16] launches a burst. It reads bytes at start, start+1, … with the address wrapping modulo 1024. Each byte appears on byte_data with a one-cycle byte_valid pulse.
- R5: For each byte the address field is first cleared for one cycle, then loaded. Strobe rises only after the address has been stable for the settle interval. It stays high for the settle interval plus one sample cycle, then falls and is held low for the settle interval.
- R6: A burst opens with load high, chip select low, program enable high, strobe low and address zero, held for the settle interval before the first address.
- R7: Offset 0xC holds the settle interval D in cycles (bits [15:0]); a value of 0 acts as 1. A burst of N bytes keeps busy high for D + N·(3D+2) + 1 cycles.
- R8: When a burst ends, seq_done pulses for one cycle. On the following cycle busy is low and the pins are in standby, and they stay there.
- R9: While busy, writes to offsets 0x0 and 0xC and further launch writes are ignored. A launch with a byte count of zero does nothing.
- R10: Offset 0x8 reads busy in bit 31 and zero elsewhere.
- R11: The program-enable pin is never driven low, whatever is written to control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when high, read when low |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from reg_addr) |
| fz_cs_n | output | 1 | Macro chip select, active low |
| fz_strobe | output | 1 | Macro sense strobe |
| fz_load | output | 1 | Macro read/load mode |
| fz_pgm_n | output | 1 | Macro program enable, active low (held high) |
| fz_addr | output | 10 | Macro byte address |
| fz_dout | input | 8 | Byte sensed by the macro |
| byte_valid | output | 1 | One-cycle pulse per burst byte |
| byte_data | output | 8 | Burst byte, valid with byte_valid |
| seq_busy | output | 1 | Sequencer active |
| seq_done | output | 1 | One-cycle pulse at end of burst |

## Verification
The assertions watch four things on every cycle. Program enable stays high. No strobe rise comes before the address has settled for the programmed interval. A session opens with load set and the address cleared. After the done pulse the pins are in standby with busy low. The assertions also cover the single-cycle shape of the valid pulse and the freezing of the control register while busy. Only the bench scenarios can show that the right bytes arrive in the right order, including the wrap past address 1023. The same holds for the exact busy length, the handling of a zero settle value or zero count, and that pokes during a burst leave its outcome unchanged.

// File: rtl/efuse_rd_pkg.sv
package efuse_rd_pkg;

    localparam int FZ_AW = 10;
    localparam int FZ_DW = 8;

    localparam logic [3:0] OFS_CTRL   = 4'h0;
    localparam logic [3:0] OFS_DOUT   = 4'h4;
    localparam logic [3:0] OFS_BURST  = 4'h8;
    localparam logic [3:0] OFS_SETTLE = 4'hC;

    localparam int CSN_B    = 0;
    localparam int STRB_B   = 1;
    localparam int LOAD_B   = 2;
    localparam int PGMN_B   = 3;
    localparam int ADDR_LSB = 6;
    localparam int GO_B     = 31;
    localparam int CNT_LSB  = 16;
    localparam int BUSY_B   = 31;

    typedef struct packed {
        logic [FZ_AW-1:0] addr;
        logic             pgmn;
        logic             load;
        logic             strobe;
        logic             csn;
    } fz_pins_t;

    localparam fz_pins_t PINS_STANDBY = '{addr: '0, pgmn: 1'b1, load: 1'b0,
                                          strobe: 1'b0, csn: 1'b1};
    localparam fz_pins_t PINS_OPEN    = '{addr: '0, pgmn: 1'b1, load: 1'b1,
                                          strobe: 1'b0, csn: 1'b0};

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_OPEN,
        SQ_CLR,
        SQ_ADDR,
        SQ_STRB,
        SQ_SAMP,
        SQ_LOW,
        SQ_PARK
    } seq_state_t;

    function automatic logic [31:0] pins_to_word(input fz_pins_t p);
        logic [31:0] w;
        w = '0;
        w[CSN_B]  = p.csn;
        w[STRB_B] = p.strobe;
        w[LOAD_B] = p.load;
        w[PGMN_B] = p.pgmn;
        w[ADDR_LSB +: FZ_AW] = p.addr;
        return w;
    endfunction

    // program enable is never taken from software: the array stays read-only
    function automatic fz_pins_t word_to_pins(input logic [31:0] w);
        fz_pins_t p;
        p.csn    = w[CSN_B];
        p.strobe = w[STRB_B];
        p.load   = w[LOAD_B];
        p.pgmn   = 1'b1;
        p.addr   = w[ADDR_LSB +: FZ_AW];
        return p;
    endfunction

endpackage

// File: rtl/efuse_settle_timer.sv
module efuse_settle_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DLY_W-1:0] dly,
    output logic             expired
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= (dly == '0) ? '0 : dly - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/efuse_burst_seq.sv
module efuse_burst_seq
    import efuse_rd_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [FZ_AW-1:0] go_addr,
    input  logic [CNT_W-1:0] go_cnt,
    input  logic [DLY_W-1:0] dly,
    output logic             busy,
    output logic             done,
    output logic             sample,
    output fz_pins_t         pins
);
    localparam int STAB_W = DLY_W + 1;

    seq_state_t       state_q, state_d;
    fz_pins_t         pins_q, pins_d;
    logic [FZ_AW-1:0] addr_q, addr_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic             tmr_start, tmr_exp;

    efuse_settle_timer #(.DLY_W(DLY_W)) tmr_i (
        .clk     (clk),
        .rst     (rst),
        .start   (tmr_start),
        .dly     (dly),
        .expired (tmr_exp)
    );

    always_comb begin
        state_d   = state_q;
        pins_d    = pins_q;
        addr_d    = addr_q;
        left_d    = left_q;
        tmr_start = 1'b0;
        done      = 1'b0;
        sample    = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (go) begin
                    state_d   = SQ_OPEN;
                    tmr_start = 1'b1;
                    pins_d    = PINS_OPEN;
                    addr_d    = go_addr;
                    left_d    = go_cnt;
                end
            end
            SQ_OPEN: begin
                if (tmr_exp) begin
                    state_d     = SQ_CLR;
                    pins_d.addr = '0;
                end
            end
            SQ_CLR: begin
                state_d     = SQ_ADDR;
                tmr_start   = 1'b1;
                pins_d.addr = addr_q;
            end
            SQ_ADDR: begin
                if (tmr_exp) begin
                    state_d       = SQ_STRB;
                    tmr_start     = 1'b1;
                    pins_d.strobe = 1'b1;
                end
            end
            SQ_STRB: begin
                if (tmr_exp) begin
                    state_d = SQ_SAMP;
                end
            end
            SQ_SAMP: begin
                sample        = 1'b1;
                state_d       = SQ_LOW;
                tmr_start     = 1'b1;
                pins_d.strobe = 1'b0;
                left_d        = left_q - 1'b1;
                addr_d        = addr_q + 1'b1;
            end
            SQ_LOW: begin
                if (tmr_exp) begin
                    if (left_q == '0) begin
                        state_d = SQ_PARK;
                        pins_d  = PINS_STANDBY;
                    end else begin
                        state_d     = SQ_CLR;
                        pins_d.addr = '0;
                    end
                end
            end
            SQ_PARK: begin
                done    = 1'b1;
                state_d = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            pins_q  <= PINS_STANDBY;
            addr_q  <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            pins_q  <= pins_d;
            addr_q  <= addr_d;
            left_q  <= left_d;
        end
    end

    assign busy = (state_q != SQ_IDLE);
    assign pins = pins_q;

    // cycles the driven address has held its value (checker support)
    logic [STAB_W-1:0] stab_q;
    logic [STAB_W-1:0] dly_eff;
    assign dly_eff = (dly == '0) ? STAB_W'(1) : STAB_W'(dly);

    always_ff @(posedge clk) begin
        if (rst) begin
            stab_q <= '0;
        end else if (pins_d.addr != pins_q.addr) begin
            stab_q <= '0;
        end else if (stab_q != '1) begin
            stab_q <= stab_q + 1'b1;
        end
    end

    // R5
    strobe_after_settle_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $rose(pins_q.strobe)) |-> (stab_q >= dly_eff));

    // R6
    open_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pins_q.csn) |-> (pins_q.load && pins_q.pgmn && !pins_q.strobe
                               && pins_q.addr == '0));

endmodule

// File: rtl/efuse_reg_if.sv
module efuse_reg_if
    import efuse_rd_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int DLY_W   = 16,
    parameter int DLY_RST = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_en,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             busy,
    input  logic             park,
    input  logic             sample,
    input  fz_pins_t         cur_pins,
    input  logic [FZ_DW-1:0] fz_dout,
    output fz_pins_t         sw_pins,
    output logic             go,
    output logic [FZ_AW-1:0] go_addr,
    output logic [CNT_W-1:0] go_cnt,
    output logic [DLY_W-1:0] dly_q,
    output logic [FZ_DW-1:0] dout_q,
    output logic             valid_q
);
    logic     wr;
    fz_pins_t sw_q;

    assign wr      = reg_en && reg_we;
    assign go_addr = reg_wdata[FZ_AW-1:0];
    assign go_cnt  = reg_wdata[CNT_LSB +: CNT_W];
    assign go      = wr && (reg_addr == OFS_BURST) && reg_wdata[GO_B]
                     && !busy && (go_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst || park) begin
            sw_q <= PINS_STANDBY;
        end else if (wr && reg_addr == OFS_CTRL && !busy) begin
            sw_q <= word_to_pins(reg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q <= DLY_W'(DLY_RST);
        end else if (wr && reg_addr == OFS_SETTLE && !busy) begin
            dly_q <= reg_wdata[DLY_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= sample;
            if (sample || (!busy && cur_pins.strobe)) begin
                dout_q <= fz_dout;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_CTRL:   reg_rdata = pins_to_word(cur_pins);
            OFS_DOUT:   reg_rdata = {{(32-FZ_DW){1'b0}}, dout_q};
            OFS_BURST:  reg_rdata = {busy, 31'd0};
            OFS_SETTLE: reg_rdata = {{(32-DLY_W){1'b0}}, dly_q};
            default:    reg_rdata = '0;
        endcase
    end

    assign sw_pins = sw_q;

    // R9
    ctrl_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !park && wr && reg_addr == OFS_CTRL) |=> $stable(sw_q));

    // R9
    settle_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr && reg_addr == OFS_SETTLE) |=> $stable(dly_q));

endmodule

// File: rtl/efuse_rd_ctrl.sv
module efuse_rd_ctrl
    import efuse_rd_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int DLY_W   = 16,
    parameter int DLY_RST = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_en,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             fz_cs_n,
    output logic             fz_strobe,
    output logic             fz_load,
    output logic             fz_pgm_n,
    output logic [FZ_AW-1:0] fz_addr,
    input  logic [FZ_DW-1:0] fz_dout,
    output logic             byte_valid,
    output logic [FZ_DW-1:0] byte_data,
    output logic             seq_busy,
    output logic             seq_done
);
    fz_pins_t         sw_pins, seq_pins, cur_pins;
    logic             go, sample;
    logic [FZ_AW-1:0] go_addr;
    logic [CNT_W-1:0] go_cnt;
    logic [DLY_W-1:0] dly;

    efuse_reg_if #(.CNT_W(CNT_W), .DLY_W(DLY_W), .DLY_RST(DLY_RST)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (seq_busy),
        .park      (seq_done),
        .sample    (sample),
        .cur_pins  (cur_pins),
        .fz_dout   (fz_dout),
        .sw_pins   (sw_pins),
        .go        (go),
        .go_addr   (go_addr),
        .go_cnt    (go_cnt),
        .dly_q     (dly),
        .dout_q    (byte_data),
        .valid_q   (byte_valid)
    );

    efuse_burst_seq #(.CNT_W(CNT_W), .DLY_W(DLY_W)) seq_i (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .go_addr (go_addr),
        .go_cnt  (go_cnt),
        .dly     (dly),
        .busy    (seq_busy),
        .done    (seq_done),
        .sample  (sample),
        .pins    (seq_pins)
    );

    assign cur_pins  = seq_busy ? seq_pins : sw_pins;
    assign fz_cs_n   = cur_pins.csn;
    assign fz_strobe = cur_pins.strobe;
    assign fz_load   = cur_pins.load;
    assign fz_pgm_n  = cur_pins.pgmn;
    assign fz_addr   = cur_pins.addr;

    // R11
    pgm_inactive_chk: assert property (@(posedge clk) disable iff (rst)
        fz_pgm_n);

    // R4
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    // R8
    park_state_chk: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> (!seq_busy && fz_cs_n && fz_pgm_n && !fz_load
                      && !fz_strobe && fz_addr == '0));

endmodule

// File: tb/efuse_rd_ctrl_tb.sv
module efuse_rd_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fz_cs_n, fz_strobe, fz_load, fz_pgm_n;
    logic [9:0]  fz_addr;
    logic [7:0]  fz_dout;
    logic        byte_valid, seq_busy, seq_done;
    logic [7:0]  byte_data;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    efuse_rd_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fz_cs_n(fz_cs_n), .fz_strobe(fz_strobe), .fz_load(fz_load),
        .fz_pgm_n(fz_pgm_n), .fz_addr(fz_addr), .fz_dout(fz_dout),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .seq_busy(seq_busy), .seq_done(seq_done)
    );

    function automatic logic [7:0] fz_val(input logic [9:0] a);
        return 8'(a * 7) ^ 8'(a >> 3) ^ 8'hC3;
    endfunction

    function automatic int exp_busy(input int n, input int d);
        int de;
        de = (d == 0) ? 1 : d;
        return de + n * (3 * de + 2) + 1;
    endfunction

    // fuse array model: answers only in an open read session while strobed
    assign fz_dout = (!fz_cs_n && fz_load && fz_strobe) ? fz_val(fz_addr) : 8'h00;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor
    logic [7:0] cap [0:255];
    int  cap_n = 0, busy_n = 0, done_n = 0;
    int  cur_de = 1;
    int  stab = 0;
    logic [9:0] prev_a = '0;
    logic       prev_s = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid && cap_n < 256) begin
                cap[cap_n] = byte_data;
                cap_n++;
            end
            if (seq_busy) busy_n++;
            if (seq_done) done_n++;
            if (fz_addr == prev_a) stab++;
            else stab = 0;
            if (seq_busy && fz_strobe && !prev_s) begin
                // R5 strobe rises only after the address settled
                chk(stab >= cur_de, "R5", stab, cur_de);
            end
            if (fz_pgm_n !== 1'b1) begin
                chk(1'b0, "R11", fz_pgm_n, 1);
            end
            prev_a = fz_addr;
            prev_s = fz_strobe;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1;
        d = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic launch(input int start, input int n, input int d);
        wr(4'hC, 32'(d));
        cap_n = 0; busy_n = 0; done_n = 0;
        cur_de = (d == 0) ? 1 : d;
        wr(4'h8, 32'h8000_0000 | (32'(n) << 16) | 32'(start & 10'h3FF));
        @(negedge clk);
        // R6 session opening pin state
        chk(!fz_cs_n && fz_load && fz_pgm_n && !fz_strobe && fz_addr == 0,
            "R6", {fz_addr, fz_pgm_n, fz_load, fz_strobe, fz_cs_n}, 14'h000C);
    endtask

    task automatic finish_check(input int start, input int n, input int d);
        int guard;
        logic [31:0] r;
        guard = 0;
        while (seq_busy && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        chk(cap_n == n, "R4 count", cap_n, n);
        for (int i = 0; i < n && i < cap_n; i++) begin
            chk(cap[i] == fz_val(10'(start + i)), "R4 byte", cap[i],
                fz_val(10'(start + i)));
        end
        chk(busy_n == exp_busy(n, d), "R7 busy length", busy_n, exp_busy(n, d));
        chk(done_n == 1, "R8 done pulse", done_n, 1);
        rd(4'h0, r);
        chk(r == 32'h9, "R8 standby", r, 32'h9);
        rd(4'h4, r);
        chk(r == {24'd0, fz_val(10'(start + n - 1))}, "R3 last byte", r,
            {24'd0, fz_val(10'(start + n - 1))});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(4'h0, r); chk(r == 32'h9, "R1 ctrl", r, 32'h9);
        rd(4'h4, r); chk(r == 0, "R1 dout", r, 0);
        rd(4'h8, r); chk(r == 0, "R1 status", r, 0);
        rd(4'hC, r); chk(r == 100, "R1 settle", r, 100);
        chk(!seq_busy, "R1 busy", seq_busy, 0);

        // R2 / R11 direct pin control, program enable cannot be lowered
        wr(4'h0, 32'hFFFF_0000 | (32'h2B5 << 6) | 32'h30 | 32'h6);
        rd(4'h0, r);
        chk(r == ((32'h2B5 << 6) | 32'hE), "R2 ctrl readback", r,
            (32'h2B5 << 6) | 32'hE);
        chk(fz_addr == 10'h2B5 && fz_strobe && fz_load && !fz_cs_n, "R2 pins",
            {fz_addr, fz_load, fz_strobe, fz_cs_n}, {10'h2B5, 3'b110});
        chk(fz_pgm_n == 1'b1, "R11 pgm high", fz_pgm_n, 1);

        // R3 manual read through strobe
        wr(4'h0, (32'h13A << 6) | 32'h6);
        wr(4'h0, (32'h13A << 6) | 32'h4);
        rd(4'h4, r);
        chk(r == {24'd0, fz_val(10'h13A)}, "R3 manual dout", r,
            {24'd0, fz_val(10'h13A)});
        wr(4'h0, 32'h9);

        // R4 R5 R6 R7 R8 directed burst
        launch(5, 3, 2);
        finish_check(5, 3, 2);

        // R4 address wrap past 1023
        launch(1022, 4, 1);
        finish_check(1022, 4, 1);

        // R7 zero settle acts as one
        launch(7, 2, 0);
        finish_check(7, 2, 0);

        // R9 zero count launches nothing
        busy_n = 0; done_n = 0;
        wr(4'h8, 32'h8000_0000 | 32'd40);
        repeat (5) @(negedge clk);
        chk(busy_n == 0 && done_n == 0, "R9 zero count", busy_n, 0);

        // R9 R10 pokes during a burst are ignored
        launch(100, 2, 3);
        rd(4'h8, r);
        chk(r == 32'h8000_0000, "R10 status busy", r, 32'h8000_0000);
        wr(4'h0, 32'h0);
        wr(4'h8, 32'h8000_0000 | (32'd5 << 16) | 32'd200);
        wr(4'hC, 32'd9);
        finish_check(100, 2, 3);
        rd(4'hC, r);
        chk(r == 3, "R9 settle frozen", r, 3);
        rd(4'h8, r);
        chk(r == 0, "R10 status idle", r, 0);

        // random bursts
        for (int k = 0; k < 12; k++) begin
            int s, n, d;
            s = int'($urandom_range(0, 1023));
            n = int'($urandom_range(1, 6));
            d = int'($urandom_range(0, 5));
            launch(s, n, d);
            finish_check(s, n, d);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule